// File: doc/BRIEF.md
# Fractional Serial Clock Generator

This block derives a serial bit clock from a fast reference clock. Every enabled reference cycle produces exactly one output bit, so the output is a level that the block holds for a whole number of reference cycles and then inverts. Each held level is called a state. A configuration word sets three unsigned fields: a base width A, a split count B and a span count C.

A repeating pattern starts with the narrow states and ends with the wide states. There are (C - B) narrow states of A cycles each, then (B + 1) wide states of A + 1 cycles each. One pattern therefore lasts (C - B)·A + (B + 1)·(A + 1) reference cycles. Mixing the two widths gives an average divide ratio of A + (B + 1)/(C + 1). The average frequency lies between ref/(A + 1) and ref/A.

A new word is taken either on an explicit load strobe or at the end of a pattern, so no state is ever cut short. An optional one-cycle marker flags the first bit of every pattern. An enable input pauses the generator without losing its place in the pattern.

Top module: `frac_bitclk_gen`

## Requirements
- R1: The configuration word is split as A = bits [31:22], B = bits [21:12] and C = bits [11:0], all unsigned.
- R2: While enabled, the block advances one output bit per reference cycle. A pattern is (C - B) states of A cycles followed by (B + 1) states of A + 1 cycles, and then it repeats. With A=2, B=2, C=7 the stream is 1100110011000111000, repeating.
- R3: The output level inverts at every state boundary. This includes the change from narrow to wide states and the wrap from one pattern to the next, so a pattern with an odd state count starts its successor at level 0.
- R4: The first output bit after a synchronous reset or a load strobe is level 1. It is the first bit of the first state of a fresh pattern.
- R5: The pattern marker is 1 during the first bit of every pattern, whether that pattern began by reset, load or wrap. It is 0 during every other bit.
- R6: A word on the configuration input is sampled only in the cycle that ends a pattern or on a load strobe. Changing it in the middle of a pattern leaves the rest of that pattern unchanged.
- R7: When C is less than or equal to B, the narrow phase is empty and every state is A + 1 cycles wide.
- R8: When A is zero, a narrow state lasts one cycle instead of zero cycles.
- R9: While enable is low and no load is applied, the output, the marker and the position in the pattern all hold. A load strobe restarts the pattern even when enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; one output bit per cycle |
| rst | input | 1 | Synchronous reset, active high; also takes the configuration word |
| div_word | input | 32 | Configuration word holding A, B and C |
| load | input | 1 | Takes div_word at once and restarts the pattern |
| en | input | 1 | Advances the generator by one bit when high |
| bit_clk | output | 1 | Generated clock level |
| pat_start | output | 1 | High during the first bit of each pattern |

## Verification
The assertions watch several things on every cycle. The level inverts exactly when the sequencer reports the end of a state and holds at all other times. The in-state counter stays below the current width. The active widths change only when a pattern ends or a load arrives. A pause freezes everything, and the marker follows the end of each pattern. Whether the widths and state counts really match A, B and C can only be shown by the bench scenarios, which compare whole bit streams against a reference model. Those scenarios cover the worked example, odd state counts across a wrap, a word change in the middle of a pattern, an empty narrow phase, a zero base width and an irregular enable.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

   typedef enum logic {
      PH_NARROW = 1'b0,
      PH_WIDE   = 1'b1
   } fcg_phase_e;

   function automatic int fcg_max(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/fcg_cfg_decode.sv
module fcg_cfg_decode
   import fcg_pkg::*;
#(
   parameter int AW     = 10,
   parameter int BW     = 10,
   parameter int CW     = 12,
   parameter int WORD_W = AW + BW + CW,
   parameter int WID_W  = AW + 1,
   parameter int CNT_W  = fcg_max(CW, BW + 1)
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [WID_W-1:0]  narrow_w_o,
   output logic [WID_W-1:0]  wide_w_o,
   output logic [CNT_W-1:0]  narrow_n_o,
   output logic [CNT_W-1:0]  wide_n_o,
   output fcg_phase_e        first_ph_o
);

   logic [AW-1:0]    fld_a;
   logic [BW-1:0]    fld_b;
   logic [CW-1:0]    fld_c;
   logic [CNT_W-1:0] ext_b;
   logic [CNT_W-1:0] ext_c;

   // Field positions: A on top, C at the bottom, B between them.
   assign fld_a = word_i[WORD_W-1 -: AW];
   assign fld_b = word_i[CW +: BW];
   assign fld_c = word_i[0 +: CW];

   assign ext_b = CNT_W'(fld_b);
   assign ext_c = CNT_W'(fld_c);

   always_comb begin
      // An empty narrow phase when C does not exceed B.
      narrow_n_o = (ext_c > ext_b) ? (ext_c - ext_b) : '0;
      wide_n_o   = ext_b + CNT_W'(1);
      wide_w_o   = WID_W'(fld_a) + WID_W'(1);
      // A zero base width is stretched to a single cycle.
      narrow_w_o = (fld_a == '0) ? WID_W'(1) : WID_W'(fld_a);
      first_ph_o = (narrow_n_o == '0) ? PH_WIDE : PH_NARROW;
   end

endmodule

// File: rtl/fcg_phase_seq.sv
module fcg_phase_seq
   import fcg_pkg::*;
#(
   parameter int WID_W = 11,
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart_i,
   input  logic             en_i,
   input  fcg_phase_e       seed_ph_i,
   input  logic [WID_W-1:0] narrow_w_i,
   input  logic [WID_W-1:0] wide_w_i,
   input  logic [CNT_W-1:0] narrow_n_i,
   input  logic [CNT_W-1:0] wide_n_i,
   output logic             state_end_o,
   output logic             pat_end_o,
   output logic [WID_W-1:0] bit_cnt_o,
   output logic [WID_W-1:0] cur_w_o
);

   logic [WID_W-1:0] bit_q;
   logic [CNT_W-1:0] st_q;
   fcg_phase_e       ph_q;
   logic [CNT_W-1:0] cur_n;
   logic             phase_end;
   logic             reseed;

   always_comb begin
      cur_w_o     = (ph_q == PH_NARROW) ? narrow_w_i : wide_w_i;
      cur_n       = (ph_q == PH_NARROW) ? narrow_n_i : wide_n_i;
      state_end_o = (bit_q == cur_w_o - WID_W'(1));
      phase_end   = state_end_o && (st_q == cur_n - CNT_W'(1));
      pat_end_o   = phase_end && (ph_q == PH_WIDE);
   end

   // A wrap re-seeds exactly like a restart; only the level differs.
   assign reseed = rst || restart_i || (en_i && pat_end_o);

   always_ff @(posedge clk) begin
      if (reseed) begin
         bit_q <= '0;
         st_q  <= '0;
         ph_q  <= seed_ph_i;
      end else if (en_i) begin
         if (state_end_o) begin
            bit_q <= '0;
            if (phase_end) begin
               st_q <= '0;
               ph_q <= PH_WIDE;
            end else begin
               st_q <= st_q + CNT_W'(1);
            end
         end else begin
            bit_q <= bit_q + WID_W'(1);
         end
      end
   end

   assign bit_cnt_o = bit_q;

endmodule

// File: rtl/fcg_level_out.sv
module fcg_level_out #(
   parameter bit PULSE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic restart_i,
   input  logic en_i,
   input  logic state_end_i,
   input  logic pat_end_i,
   output logic level_o,
   output logic start_o
);

   always_ff @(posedge clk) begin
      if (rst || restart_i)
         level_o <= 1'b1;
      else if (en_i && state_end_i)
         level_o <= ~level_o;
   end

   generate
      if (PULSE_EN) begin : g_marker
         always_ff @(posedge clk) begin
            if (rst || restart_i)
               start_o <= 1'b1;
            else if (en_i)
               start_o <= pat_end_i;
         end
      end else begin : g_no_marker
         logic unused_pat_end;
         assign unused_pat_end = pat_end_i;
         assign start_o        = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/frac_bitclk_gen.sv
module frac_bitclk_gen
   import fcg_pkg::*;
#(
   parameter int AW       = 10,
   parameter int BW       = 10,
   parameter int CW       = 12,
   parameter bit PULSE_EN = 1'b1,
   parameter int WORD_W   = AW + BW + CW,
   parameter int WID_W    = AW + 1,
   parameter int CNT_W    = fcg_max(CW, BW + 1)
) (
   input  logic              ref_clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] div_word,
   input  logic              load,
   input  logic              en,
   output logic              bit_clk,
   output logic              pat_start
);

   generate
      if (AW < 1 || BW < 1 || CW < 1) begin : g_bad_field
         $error("frac_bitclk_gen: every field needs at least one bit");
      end
      if (WORD_W != AW + BW + CW) begin : g_bad_word
         $error("frac_bitclk_gen: word width must equal the field sum");
      end
      if (WID_W < AW + 1) begin : g_bad_wid
         $error("frac_bitclk_gen: width counter too narrow for A+1");
      end
      if (CNT_W < CW || CNT_W < BW + 1) begin : g_bad_cnt
         $error("frac_bitclk_gen: state counter too narrow");
      end
   endgenerate

   logic [WID_W-1:0] dec_narrow_w, dec_wide_w;
   logic [CNT_W-1:0] dec_narrow_n, dec_wide_n;
   fcg_phase_e       dec_first_ph;

   logic [WID_W-1:0] act_narrow_w, act_wide_w;
   logic [CNT_W-1:0] act_narrow_n, act_wide_n;

   logic             state_end, pat_end;
   logic [WID_W-1:0] bit_cnt, cur_w;
   logic             take;

   fcg_cfg_decode #(
      .AW(AW), .BW(BW), .CW(CW),
      .WORD_W(WORD_W), .WID_W(WID_W), .CNT_W(CNT_W)
   ) u_dec (
      .word_i     (div_word),
      .narrow_w_o (dec_narrow_w),
      .wide_w_o   (dec_wide_w),
      .narrow_n_o (dec_narrow_n),
      .wide_n_o   (dec_wide_n),
      .first_ph_o (dec_first_ph)
   );

   // The decoded word is held only at reset, load or pattern end.
   assign take = rst || load || (en && pat_end);

   always_ff @(posedge ref_clk) begin
      if (take) begin
         act_narrow_w <= dec_narrow_w;
         act_wide_w   <= dec_wide_w;
         act_narrow_n <= dec_narrow_n;
         act_wide_n   <= dec_wide_n;
      end
   end

   fcg_phase_seq #(
      .WID_W(WID_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk         (ref_clk),
      .rst         (rst),
      .restart_i   (load),
      .en_i        (en),
      .seed_ph_i   (dec_first_ph),
      .narrow_w_i  (act_narrow_w),
      .wide_w_i    (act_wide_w),
      .narrow_n_i  (act_narrow_n),
      .wide_n_i    (act_wide_n),
      .state_end_o (state_end),
      .pat_end_o   (pat_end),
      .bit_cnt_o   (bit_cnt),
      .cur_w_o     (cur_w)
   );

   fcg_level_out #(
      .PULSE_EN(PULSE_EN)
   ) u_lvl (
      .clk         (ref_clk),
      .rst         (rst),
      .restart_i   (load),
      .en_i        (en),
      .state_end_i (state_end),
      .pat_end_i   (pat_end),
      .level_o     (bit_clk),
      .start_o     (pat_start)
   );

endmodule

// File: rtl/frac_bitclk_chk.sv
module frac_bitclk_chk #(
   parameter int WID_W    = 11,
   parameter bit PULSE_EN = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             load,
   input logic             en,
   input logic             bit_clk,
   input logic             pat_start,
   input logic             state_end,
   input logic             pat_end,
   input logic [WID_W-1:0] bit_cnt,
   input logic [WID_W-1:0] cur_w,
   input logic [WID_W-1:0] act_narrow_w,
   input logic [WID_W-1:0] act_wide_w
);

   a_r4_load_restart: assert property (@(posedge clk) disable iff (rst)
      load |=> bit_clk);

   a_r4_reset_restart: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> bit_clk);

   a_r3_toggle_at_end: assert property (@(posedge clk) disable iff (rst)
      (en && !load && state_end) |=> (bit_clk != $past(bit_clk)));

   a_r2_hold_in_state: assert property (@(posedge clk) disable iff (rst)
      (en && !load && !state_end) |=> $stable(bit_clk));

   a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
      bit_cnt < cur_w);

   a_r9_pause_freezes: assert property (@(posedge clk) disable iff (rst)
      (!en && !load) |=> ($stable(bit_clk) && $stable(pat_start) && $stable(bit_cnt)));

   a_r6_cfg_held: assert property (@(posedge clk) disable iff (rst)
      (!load && !(en && pat_end)) |=> ($stable(act_narrow_w) && $stable(act_wide_w)));

   generate
      if (PULSE_EN) begin : g_marker_chk
         a_r5_marker_on_wrap: assert property (@(posedge clk) disable iff (rst)
            (en && !load && pat_end) |=> pat_start);
         a_r5_marker_off: assert property (@(posedge clk) disable iff (rst)
            (en && !load && !pat_end) |=> !pat_start);
         a_r4_marker_on_load: assert property (@(posedge clk) disable iff (rst)
            load |=> pat_start);
      end
   endgenerate

endmodule

bind frac_bitclk_gen frac_bitclk_chk #(
   .WID_W(WID_W), .PULSE_EN(PULSE_EN)
) u_chk (
   .clk          (ref_clk),
   .rst          (rst),
   .load         (load),
   .en           (en),
   .bit_clk      (bit_clk),
   .pat_start    (pat_start),
   .state_end    (state_end),
   .pat_end      (pat_end),
   .bit_cnt      (bit_cnt),
   .cur_w        (cur_w),
   .act_narrow_w (act_narrow_w),
   .act_wide_w   (act_wide_w)
);

// File: tb/tb_frac_bitclk_gen.sv
module tb_frac_bitclk_gen;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 50000;

   typedef struct {
      bit    lvl;
      bit    st;
      string tag;
   } exp_t;

   logic        ref_clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] div_word = '0;
   logic        load = 1'b0;
   logic        en = 1'b0;
   logic        bit_clk;
   logic        pat_start;

   int checks = 0;
   int errors = 0;
   int cyc_cnt = 0;
   bit done = 1'b0;
   exp_t sb[$];

   // reference model state
   int m_nw, m_ww, m_nn, m_wn;
   int m_bit, m_st, m_ph;
   bit m_lvl, m_start;

   frac_bitclk_gen dut (
      .ref_clk   (ref_clk),
      .rst       (rst),
      .div_word  (div_word),
      .load      (load),
      .en        (en),
      .bit_clk   (bit_clk),
      .pat_start (pat_start)
   );

   always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

   function automatic logic [31:0] mk(input int a, input int b, input int c);
      return {a[9:0], b[9:0], c[11:0]};   // R1 field layout
   endfunction

   task automatic m_take(input logic [31:0] w);
      int a, b, c;
      a = int'(w[31:22]);
      b = int'(w[21:12]);
      c = int'(w[11:0]);
      m_nw = (a == 0) ? 1 : a;
      m_ww = a + 1;
      m_nn = (c > b) ? c - b : 0;
      m_wn = b + 1;
      m_bit = 0;
      m_st = 0;
      m_ph = (m_nn > 0) ? 0 : 1;
      m_start = 1'b1;
   endtask

   task automatic m_step(input bit r, input bit ld, input bit e, input logic [31:0] w);
      if (r || ld) begin
         m_take(w);
         m_lvl = 1'b1;
      end else if (e) begin
         m_start = 1'b0;
         m_bit++;
         if (m_bit == ((m_ph == 0) ? m_nw : m_ww)) begin
            m_bit = 0;
            m_lvl = ~m_lvl;
            m_st++;
            if (m_st == ((m_ph == 0) ? m_nn : m_wn)) begin
               m_st = 0;
               if (m_ph == 0) m_ph = 1;
               else m_take(w);
            end
         end
      end
   endtask

   // driver: applies one cycle of stimulus and pushes the expected output
   task automatic cyc(input bit r, input bit ld, input bit e, input logic [31:0] w,
                      input string tag, input int lit = -1);
      exp_t it;
      @(negedge ref_clk);
      #1;
      rst = r;
      load = ld;
      en = e;
      div_word = w;
      m_step(r, ld, e, w);
      it.lvl = (lit < 0) ? m_lvl : bit'(lit);
      it.st = m_start;
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic run(input logic [31:0] w, input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, w, tag);
   endtask

   // monitor: pops one expected item per cycle
   always @(negedge ref_clk) begin
      if (sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         checks++;
         if (bit_clk !== it.lvl) begin
            errors++;
            $display("FAIL %s bit_clk actual %b expected %b at %0t", it.tag, bit_clk, it.lvl, $time);
         end
         checks++;
         if (pat_start !== it.st) begin
            errors++;
            $display("FAIL R5 (%s) pat_start actual %b expected %b at %0t", it.tag, pat_start, it.st, $time);
         end
      end
   end

   always @(posedge ref_clk) begin
      cyc_cnt++;
      if (cyc_cnt > WDOG_LIMIT && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d cycles expected at most %0d", cyc_cnt, WDOG_LIMIT);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      string ex;
      logic [31:0] w_ex, w1, w2, wk;
      ex = "1100110011000111000";
      w_ex = mk(2, 2, 7);

      // R4 reset state, then R2 worked example against the literal stream
      cyc(1'b1, 1'b0, 1'b0, w_ex, "R4", 1);
      for (int i = 1; i < 38; i++)
         cyc(1'b0, 1'b0, 1'b1, w_ex, "R2", int'(ex[i % 19]) - 48);

      // R1 distinct fields so a misplaced field changes the stream
      w1 = mk(5, 3, 9);
      cyc(1'b0, 1'b1, 1'b1, w1, "R1");
      run(w1, 90, "R1");
      w1 = mk(3, 6, 11);
      cyc(1'b0, 1'b1, 1'b1, w1, "R1");
      run(w1, 80, "R1");

      // R3 odd number of states: level carries across the wrap
      w1 = mk(2, 0, 2);
      cyc(1'b0, 1'b1, 1'b1, w1, "R3");
      run(w1, 30, "R3");

      // R6 word changes mid-pattern: old pattern finishes first
      w1 = mk(3, 1, 4);
      w2 = mk(1, 0, 1);
      cyc(1'b0, 1'b1, 1'b1, w1, "R6");
      run(w1, 5, "R6");
      run(w2, 40, "R6");

      // R7 C below B and C equal to B
      w1 = mk(2, 5, 3);
      cyc(1'b0, 1'b1, 1'b1, w1, "R7");
      run(w1, 40, "R7");
      w1 = mk(1, 4, 4);
      cyc(1'b0, 1'b1, 1'b1, w1, "R7");
      run(w1, 30, "R7");

      // R8 zero base width
      w1 = mk(0, 1, 4);
      cyc(1'b0, 1'b1, 1'b1, w1, "R8");
      run(w1, 30, "R8");

      // R9 irregular enable, then load while paused
      w1 = mk(3, 1, 4);
      cyc(1'b0, 1'b1, 1'b1, w1, "R9");
      for (int i = 0; i < 60; i++)
         cyc(1'b0, 1'b0, (i % 3) != 1, w1, "R9");
      cyc(1'b0, 1'b0, 1'b0, w1, "R9");
      cyc(1'b0, 1'b1, 1'b0, w_ex, "R9");
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, w_ex, "R9");
      run(w_ex, 25, "R9");

      // R4 reset in mid-stream
      cyc(1'b1, 1'b0, 1'b1, w1, "R4");
      run(w1, 20, "R4");

      // R2 widest base width with a single wide state
      wk = mk(1023, 0, 0);
      cyc(1'b0, 1'b1, 1'b1, wk, "R2");
      run(wk, 2100, "R2");

      @(negedge ref_clk);
      @(negedge ref_clk);
      @(negedge ref_clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule